// File: doc/BRIEF.md
# Interrupt Cause and Enable Mask Register Block

This block keeps a vector of pending interrupt causes and a vector of enable bits, and from them drives one level-sensitive interrupt line to a host. Hardware event inputs set cause bits. Software can set cause bits through a dedicated offset. Software clears cause bits either by writing ones to the cause offset or by reading that offset. A read returns the pending causes and then clears them.

The enable mask is never written directly. One offset ORs ones into it and another offset clears the bits where ones are written. Reading the mask-set offset returns the current mask. The interrupt line is registered. It is updated on the same clock edge as any change to the cause or the mask, so a mask change alone can raise or drop it.

A read or write is one cycle long. Read data appears on `rdata` after the clock edge that follows the read cycle, and it holds until the next read.

Top module: `irq_cause_mask`

## Requirements
- R1: After reset the cause vector and the mask are zero, `irq` is low and `rdata` is zero.
- R2: A write to word index 2 ORs `wdata` into the mask.
- R3: A write to word index 3 clears every mask bit where `wdata` is one.
- R4: A write to word index 0 clears every cause bit where `wdata` is one. Cause bits where `wdata` is zero are kept.
- R5: A write to word index 1 sets every cause bit where `wdata` is one.
- R6: A read of word index 0 puts the cause vector on `rdata` one cycle later. The same edge clears the cause vector to zero.
- R7: A read of word index 2 returns the mask and changes nothing. Reads of word indices 1 and 3 return zero and change neither the cause vector nor the mask.
- R8: Each cycle, every bit set on `event_in` sets the matching cause bit at the next edge.
- R9: When an event and a clear of the same cause bit fall in the same cycle, the bit ends up set. The clear can come from a write to word index 0 or from a read of word index 0.
- R10: `irq` is a register equal to the OR of (cause AND mask). It changes on the same edge as the cause or the mask, including when only the mask changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| addr | input | AW (2) | Word index: 0 cause read/clear, 1 cause set, 2 mask set/read, 3 mask clear |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data, valid from the edge after the read and held until the next read |
| event_in | input | DW (32) | Hardware event bits, one cycle high per event |
| irq | output | 1 | Level interrupt to the host |

## Verification
The embedded assertions check, on every cycle, several rules:
- `irq` always matches the OR of cause and mask.
- Mask-set and mask-clear writes leave the written bits set or cleared.
- Event bits are always present in the cause vector after the edge, whatever clear ran in that cycle.
- A cause read returns the prior value and leaves zero behind.

Some behaviours only the bench scenarios can show, because they need a sequence of accesses observed at the ports:
- Bits that are not written are preserved.
- Reads at the write-only offsets return zero and have no side effects.
- A mask change alone raises or drops `irq` while a cause is pending.
- The exact values survive a race between an event and a clear.

// File: rtl/irq_cause_mask.sv
module irq_cause_mask #(
  parameter int DW = 32,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] event_in,
  output logic          irq
);

  localparam logic [AW-1:0] IDX_CAUSE = AW'(0);
  localparam logic [AW-1:0] IDX_CSET  = AW'(1);
  localparam logic [AW-1:0] IDX_MSET  = AW'(2);
  localparam logic [AW-1:0] IDX_MCLR  = AW'(3);
  localparam logic [DW-1:0] ZERO      = '0;
  localparam logic [DW-1:0] ONES      = '1;

  logic [DW-1:0] cause_q, mask_q;
  logic [DW-1:0] cause_clr, cause_set, cause_d;
  logic [DW-1:0] mask_or, mask_andn, mask_d;
  logic [DW-1:0] rd_val;

  assign cause_clr = ((wr_en && addr == IDX_CAUSE) ? wdata : ZERO)
                   | ((rd_en && addr == IDX_CAUSE) ? ONES  : ZERO);
  assign cause_set = event_in | ((wr_en && addr == IDX_CSET) ? wdata : ZERO);
  assign cause_d   = (cause_q & ~cause_clr) | cause_set;

  assign mask_or   = (wr_en && addr == IDX_MSET) ? wdata : ZERO;
  assign mask_andn = (wr_en && addr == IDX_MCLR) ? wdata : ZERO;
  assign mask_d    = (mask_q | mask_or) & ~mask_andn;

  always_comb begin
    case (addr)
      IDX_CAUSE: rd_val = cause_q;
      IDX_MSET:  rd_val = mask_q;
      default:   rd_val = ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
      irq     <= 1'b0;
      rdata   <= '0;
    end else begin
      cause_q <= cause_d;
      mask_q  <= mask_d;
      irq     <= |(cause_d & mask_d);
      if (rd_en) rdata <= rd_val;
    end
  end

  a_r10_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(cause_q & mask_q));

  a_r2_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == IDX_MSET) |=> ((mask_q & $past(wdata)) == $past(wdata)));

  a_r3_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == IDX_MCLR) |=> ((mask_q & $past(wdata)) == ZERO));

  a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == IDX_CAUSE && (event_in & wdata) == ZERO)
      |=> ((cause_q & $past(wdata)) == ZERO));

  a_r8_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (event_in != ZERO) |=> ((cause_q & $past(event_in)) == $past(event_in)));

  a_r6_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == IDX_CAUSE) |=> (rdata == $past(cause_q)));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == IDX_CAUSE && event_in == ZERO) |=> (cause_q == ZERO));

  a_r7_mask_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> $stable(mask_q));

endmodule

// File: tb/irq_cause_mask_tb.sv
module irq_cause_mask_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] event_in = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  irq_cause_mask #(.DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .event_in(event_in), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic do_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse_event(input logic [DW-1:0] e);
    event_in = e;
    @(negedge clk);
    event_in = '0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rdata", rdata, 32'd0);
    do_rd(2'd0, v); check("R1 cause", v, 32'd0);
    do_rd(2'd2, v); check("R1 mask", v, 32'd0);
  endtask

  task automatic t_mask();
    logic [DW-1:0] v;
    do_wr(2'd2, 32'h0000_00F0);
    do_wr(2'd2, 32'h0F00_0000);
    do_rd(2'd2, v); check("R2 mask set OR", v, 32'h0F00_00F0);
    do_wr(2'd3, 32'h0000_0030);
    do_rd(2'd2, v); check("R3 mask clear", v, 32'h0F00_00C0);
    do_rd(2'd3, v); check("R7 read idx3 zero", v, 32'd0);
    do_rd(2'd2, v); check("R7 mask unchanged", v, 32'h0F00_00C0);
  endtask

  task automatic t_cause();
    logic [DW-1:0] v;
    do_wr(2'd1, 32'h0000_0011);
    check("R10 masked cause no irq", {31'd0, irq}, 32'd0);
    do_wr(2'd2, 32'h0000_0001);
    check("R10 irq on mask change", {31'd0, irq}, 32'd1);
    do_wr(2'd0, 32'h0000_0001);
    check("R4 w1c drops irq", {31'd0, irq}, 32'd0);
    do_rd(2'd0, v); check("R5 R4 cause value", v, 32'h0000_0010);
    do_rd(2'd0, v); check("R6 read cleared", v, 32'd0);
  endtask

  task automatic t_event();
    logic [DW-1:0] v;
    pulse_event(32'h0000_0080);
    check("R8 event irq", {31'd0, irq}, 32'd1);
    do_rd(2'd0, v); check("R8 event cause", v, 32'h0000_0080);
    check("R6 irq drops after read", {31'd0, irq}, 32'd0);
    do_rd(2'd0, v); check("R6 empty after read", v, 32'd0);
  endtask

  task automatic t_race();
    logic [DW-1:0] v;
    do_wr(2'd1, 32'h0000_0003);
    event_in = 32'h0000_0002;
    do_wr(2'd0, 32'h0000_0003);
    event_in = '0;
    do_rd(2'd0, v); check("R9 event beats w1c", v, 32'h0000_0002);
    do_wr(2'd1, 32'h0000_0008);
    event_in = 32'h0000_0004;
    do_rd(2'd0, v);
    event_in = '0;
    check("R6 read returns old", v, 32'h0000_0008);
    do_rd(2'd0, v); check("R9 event beats read clear", v, 32'h0000_0004);
  endtask

  task automatic t_side_effects();
    logic [DW-1:0] v;
    do_wr(2'd1, 32'h0000_0020);
    do_rd(2'd1, v); check("R7 read idx1 zero", v, 32'd0);
    do_rd(2'd0, v); check("R7 cause kept after idx1 read", v, 32'h0000_0020);
  endtask

  task automatic t_mask_drop();
    logic [DW-1:0] v;
    do_wr(2'd1, 32'h0000_0080);
    check("R10 irq pending", {31'd0, irq}, 32'd1);
    do_wr(2'd3, 32'hFFFF_FFFF);
    check("R10 irq drops on mask clear", {31'd0, irq}, 32'd0);
    do_rd(2'd2, v); check("R3 mask all clear", v, 32'd0);
    do_rd(2'd0, v); check("R10 cause kept", v, 32'h0000_0080);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_cause();
    t_event();
    t_race();
    t_side_effects();
    t_mask_drop();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule